// File: doc/BRIEF.md
# I2C Controller Byte-Cycle Engine

This block is the sequencing core of an I2C bus controller. A host loads a target address byte and a transmit byte, then writes a four-bit command. Each command runs one byte cycle on the bus. The cycle may open with a START or a repeated START, which is followed by the address byte. It then moves one data byte in the direction held in the address byte. It may close with a STOP, or it may leave SCL held low so that the next command can continue the transfer or issue a repeated START.

The block drives the bus through open-drain enables. A high enable pulls the line low. It reads the line levels back on `scl_i` and `sda_i`. Bit timing comes from an external tick: each bit takes four ticks, two with SCL low and two with SCL released. A seven-bit status word reports the outcome:
- busy
- error summary
- address NACK
- data NACK
- arbitration lost
- controller idle
- bus busy

One interrupt line is raised at the end of every command. It has a raw flag, a mask bit and a write-one-to-clear pulse.

Top module: `i2c_ctl_engine`

## Requirements
- R1: The address byte is transmitted MSB first right after a START. Bits [7:1] of the byte hold the 7-bit target address. Bit 0 is the direction: 1 reads from the target and 0 writes to it. The direction is latched when the START is issued.
- R2: A command write is accepted only when bit 0 (run) is 1 and the controller is idle. All other command writes have no effect on the bus or on the status.
- R3: With command bit 1 (start) set, the cycle opens with a START, or with a repeated START if SCL is being held. The address byte follows. With bit 1 clear, only the data byte is run, in the direction latched at the last START.
- R4: With command bit 2 (stop) set, a STOP follows the data byte. With bit 2 clear, the cycle ends with SCL still driven low and the bus remains busy.
- R5: On a read, the received byte appears on `rx_data` at the end of the cycle. In the ninth clock the controller pulls SDA low (ACK) if command bit 3 was set and releases it (NACK) if bit 3 was clear.
- R6: On a write, the byte last written through the transmit port is sent MSB first. A released SDA in the ninth clock sets status bit 3 (data NACK).
- R7: A released SDA in the address acknowledge clock sets status bit 2 (address NACK). The data byte is then skipped and a STOP is issued regardless of command bit 2.
- R8: If the controller releases SDA while SCL is high and samples SDA low, it releases both lines at once. It then sets status bit 4 (arbitration lost) and ends the command.
- R9: Status bit 1 (error) is 1 exactly when any of status bits 2, 3 or 4 is 1. All four of these flags clear when a command is accepted.
- R10: Status bit 0 (busy) rises BUSY_DELAY clocks after the clock edge that accepts a command and falls when the command ends. Status bit 5 (idle) falls on the accepting edge and rises when the command ends.
- R11: Status bit 6 (bus busy) sets when a START is seen on the lines and clears when a STOP is seen. Both conditions count, whichever master drives them. The bit changes one clock after the condition is sampled.
- R12: `irq_raw` sets at the end of every command, whether the command succeeded or failed. The `irq_clr` pulse clears it. `irq` equals `irq_raw` AND the mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_tick | input | 1 | Quarter-bit enable from the bit-timing generator |
| cmd_we | input | 1 | Command write strobe |
| cmd_wdata | input | 4 | Command bits: 0 run, 1 start, 2 stop, 3 ack |
| addr_we | input | 1 | Address byte write strobe |
| addr_wdata | input | 8 | Target address [7:1] and direction [0] |
| txd_we | input | 1 | Transmit byte write strobe |
| txd_wdata | input | 8 | Next byte to transmit |
| mask_we | input | 1 | Interrupt mask write strobe |
| mask_wdata | input | 1 | Interrupt mask value |
| irq_clr | input | 1 | Clear pulse for the raw interrupt |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| rx_data | output | 8 | Last received byte |
| status | output | 7 | {bus busy, idle, arb lost, data NACK, addr NACK, error, busy} |
| irq_raw | output | 1 | Raw interrupt flag |
| irq | output | 1 | Masked interrupt |

## Verification
The bench builds the block with BUSY_DELAY at its default of 4 and pulses the tick on every other clock. A whole START, address, data and STOP cycle therefore lasts about 160 clocks. This short cycle puts the following within a short run:
- the four-cycle busy window
- chained commands without a STOP
- a repeated START into a two-byte read
- a forced arbitration loss

A behavioural target on the open-drain wires decodes and answers the bus. A line monitor in the bench predicts bus busy and the masked interrupt on every clock.

// File: rtl/i2c_ctl_engine.sv
module i2c_ctl_engine #(
  parameter int BUSY_DELAY = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_tick,
  input  logic       cmd_we,
  input  logic [3:0] cmd_wdata,
  input  logic       addr_we,
  input  logic [7:0] addr_wdata,
  input  logic       txd_we,
  input  logic [7:0] txd_wdata,
  input  logic       mask_we,
  input  logic       mask_wdata,
  input  logic       irq_clr,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       scl_oe,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic [6:0] status,
  output logic       irq_raw,
  output logic       irq
);

  localparam int DCW = (BUSY_DELAY > 2) ? $clog2(BUSY_DELAY) : 1;
  localparam logic [DCW-1:0] DLOAD = DCW'(BUSY_DELAY - 1);

  typedef enum logic [2:0] {S_IDLE, S_WAIT, S_START, S_BIT, S_STOP, S_DONE} st_t;
  st_t st;

  logic [1:0]     q;
  logic [3:0]     bitn;
  logic [7:0]     sh, addr_r, txd_r;
  logic [DCW-1:0] dcnt;
  logic is_addr, rd_r, want_start, want_stop, ack_en, nack_s;
  logic f_adr, f_dat, f_arb, f_err, mask_r;
  logic scl_q, sda_q, bbusy;

  logic idle_w, busy_w, tx_slot, drive_low, arb_chk, accept;
  assign idle_w    = (st == S_IDLE);
  assign busy_w    = (st != S_IDLE) && (st != S_WAIT);
  assign accept    = idle_w && cmd_we && cmd_wdata[0];
  assign tx_slot   = is_addr | ~rd_r;
  assign drive_low = (bitn == 4'd8) ? (~tx_slot & ack_en) : (tx_slot & ~sh[7]);
  assign arb_chk   = (bitn != 4'd8) & tx_slot & sh[7];

  assign status = {bbusy, idle_w, f_arb, f_dat, f_adr, f_err, busy_w};
  assign irq    = irq_raw & mask_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bitn <= '0; sh <= '0; dcnt <= '0;
      addr_r <= '0; txd_r <= '0; rx_data <= '0;
      is_addr <= 1'b0; rd_r <= 1'b0; want_start <= 1'b0; want_stop <= 1'b0;
      ack_en <= 1'b0; nack_s <= 1'b0;
      f_adr <= 1'b0; f_dat <= 1'b0; f_arb <= 1'b0; f_err <= 1'b0;
      scl_oe <= 1'b0; sda_oe <= 1'b0;
    end else begin
      if (addr_we) addr_r <= addr_wdata;
      if (txd_we)  txd_r  <= txd_wdata;
      case (st)
        S_IDLE: if (accept) begin
          want_start <= cmd_wdata[1];
          want_stop  <= cmd_wdata[2];
          ack_en     <= cmd_wdata[3];
          f_adr <= 1'b0; f_dat <= 1'b0; f_arb <= 1'b0; f_err <= 1'b0;
          dcnt <= DLOAD;
          st   <= S_WAIT;
        end
        S_WAIT: begin
          if (dcnt == '0) begin
            q <= '0;
            if (want_start) st <= S_START;
            else begin
              st      <= S_BIT;
              is_addr <= 1'b0;
              bitn    <= '0;
              sh      <= rd_r ? 8'hFF : txd_r;
            end
          end else dcnt <= dcnt - 1'b1;
        end
        S_START: if (scl_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b0;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b1;
            default: begin
              scl_oe  <= 1'b1;
              st      <= S_BIT;
              is_addr <= 1'b1;
              rd_r    <= addr_r[0];
              sh      <= addr_r;
              bitn    <= '0;
            end
          endcase
        end
        S_BIT: if (scl_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= drive_low;
            2'd1: scl_oe <= 1'b0;
            2'd2: begin
              if (arb_chk && !sda_i) begin
                scl_oe <= 1'b0; sda_oe <= 1'b0;
                f_arb  <= 1'b1; f_err  <= 1'b1;
                st     <= S_DONE;
              end else if (bitn == 4'd8) nack_s <= sda_i;
              else sh <= {sh[6:0], sda_i};
            end
            default: begin
              scl_oe <= 1'b1;
              if (bitn != 4'd8) bitn <= bitn + 4'd1;
              else begin
                bitn <= '0;
                if (is_addr) begin
                  if (nack_s) begin
                    f_adr <= 1'b1; f_err <= 1'b1;
                    st    <= S_STOP;
                  end else begin
                    is_addr <= 1'b0;
                    sh      <= rd_r ? 8'hFF : txd_r;
                  end
                end else begin
                  if (rd_r) rx_data <= sh;
                  else if (nack_s) begin
                    f_dat <= 1'b1; f_err <= 1'b1;
                  end
                  st <= want_stop ? S_STOP : S_DONE;
                end
              end
            end
          endcase
        end
        S_STOP: if (scl_tick) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_oe <= 1'b1;
            2'd1: scl_oe <= 1'b0;
            2'd2: sda_oe <= 1'b0;
            default: st <= S_DONE;
          endcase
        end
        S_DONE:  st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_raw <= 1'b0;
      mask_r  <= 1'b0;
    end else begin
      if (mask_we) mask_r <= mask_wdata;
      if (st == S_DONE) irq_raw <= 1'b1;
      else if (irq_clr) irq_raw <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1; sda_q <= 1'b1; bbusy <= 1'b0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (scl_i && scl_q && sda_q && !sda_i) bbusy <= 1'b1;
      else if (scl_i && scl_q && !sda_q && sda_i) bbusy <= 1'b0;
    end
  end

  assert_busy_late_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (!status[0] && !status[5]));

  assert_err_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    status[1] == (status[2] | status[3] | status[4]));

  assert_arb_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_arb) |-> (!scl_oe && !sda_oe));

  assert_adr_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(f_adr) |-> (st == S_STOP));

  assert_bus_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && scl_q && sda_q && !sda_i) |=> status[6]);

  assert_irq_clear_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && st != S_DONE) |=> !irq_raw);

endmodule

// File: tb/tb_i2c_ctl_engine.sv
`timescale 1ns/1ps
module tb_i2c_ctl_engine;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0, scl_tick = 1'b0;
  logic cmd_we = 0, addr_we = 0, txd_we = 0, mask_we = 0, mask_wdata = 0, irq_clr = 0;
  logic [3:0] cmd_wdata = '0;
  logic [7:0] addr_wdata = '0, txd_wdata = '0;
  logic scl_oe, sda_oe, irq_raw, irq;
  logic [7:0] rx_data;
  logic [6:0] status;
  logic scl, sda;
  logic tgt_low = 1'b0, force_low = 1'b0;

  assign scl = ~scl_oe;
  assign sda = ~(sda_oe | tgt_low | force_low);

  i2c_ctl_engine dut (
    .clk(clk), .rst_n(rst_n), .scl_tick(scl_tick),
    .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
    .addr_we(addr_we), .addr_wdata(addr_wdata),
    .txd_we(txd_we), .txd_wdata(txd_wdata),
    .mask_we(mask_we), .mask_wdata(mask_wdata), .irq_clr(irq_clr),
    .scl_i(scl), .sda_i(sda), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .rx_data(rx_data), .status(status), .irq_raw(irq_raw), .irq(irq));

  always @(posedge clk) scl_tick <= rst_n ? ~scl_tick : 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic chk_eq(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Behavioural target and line monitor
  localparam logic [6:0] TADDR = 7'h3A;
  logic pscl = 1'b1, psda = 1'b1, exp_bb = 1'b0;
  int bitn = 0, starts = 0, stops = 0, addr_cnt = 0, wr_cnt = 0, rd_idx = 0;
  logic in_addr = 0, sel = 0, rdm = 0, mack = 0, ack_wr = 1;
  logic [7:0] rxb = '0, addr_seen = '0, wr_seen = '0, cur = '0;
  logic [7:0] rd_q [2];
  logic mask_m = 1'b0;

  always @(posedge clk) begin
    if (!rst_n) begin
      pscl = 1; psda = 1; exp_bb = 0; bitn = 0; sel = 0; tgt_low <= 1'b0;
    end else begin
      if (pscl && scl && psda && !sda) begin
        exp_bb = 1; starts++; bitn = 0; in_addr = 1; sel = 0; tgt_low <= 1'b0;
      end else if (pscl && scl && !psda && sda) begin
        exp_bb = 0; stops++; bitn = 0; sel = 0; tgt_low <= 1'b0;
      end else if (!pscl && scl) begin
        if (bitn < 8) rxb = {rxb[6:0], sda};
        else if (bitn == 8) mack = sda;
        bitn++;
      end else if (pscl && !scl) begin
        if (bitn == 8) begin
          if (in_addr) begin
            addr_seen = rxb; addr_cnt++;
            sel = (rxb[7:1] == TADDR); rdm = rxb[0];
            tgt_low <= (rxb[7:1] == TADDR);
          end else if (sel && !rdm) begin
            wr_seen = rxb; wr_cnt++; tgt_low <= ack_wr;
          end else tgt_low <= 1'b0;
        end else if (bitn == 9) begin
          tgt_low <= 1'b0;
          if (sel && rdm && (in_addr || !mack)) begin
            cur = rd_q[rd_idx]; rd_idx++;
            tgt_low <= ~cur[7];
          end
          in_addr = 0; bitn = 0;
        end else if (bitn >= 1 && bitn <= 7 && sel && rdm && !in_addr) begin
          tgt_low <= ~cur[7-bitn];
        end
      end
      pscl = scl; psda = sda;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      chk_eq("R11 bus busy per clock", status[6], exp_bb);
      chk_eq("R12 masked irq per clock", irq, irq_raw & mask_m);
    end
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end

  task automatic set_addr(input logic [7:0] b);
    @(negedge clk); addr_wdata = b; addr_we = 1; @(negedge clk); addr_we = 0;
  endtask
  task automatic set_txd(input logic [7:0] b);
    @(negedge clk); txd_wdata = b; txd_we = 1; @(negedge clk); txd_we = 0;
  endtask
  task automatic set_mask(input logic m);
    @(negedge clk); mask_wdata = m; mask_we = 1; @(posedge clk); mask_m = m;
    @(negedge clk); mask_we = 0;
  endtask
  task automatic clr_irq();
    @(negedge clk); irq_clr = 1; @(negedge clk); irq_clr = 0;
  endtask
  task automatic wr_cmd(input logic [3:0] c);
    @(negedge clk); cmd_wdata = c; cmd_we = 1; @(negedge clk); cmd_we = 0;
  endtask
  task automatic wait_idle();
    for (int n = 0; n < 5000 && !status[5]; n++) @(negedge clk);
  endtask
  task automatic run_cmd(input logic [3:0] c);
    wr_cmd(c);
    chk_eq("R10 busy low after accept", status[0], 0);
    chk_eq("R10 idle falls on accept", status[5], 0);
    for (int i = 1; i <= 4; i++) begin
      @(negedge clk);
      chk_eq("R10 busy after delay", status[0], (i == 4) ? 1 : 0);
    end
    wait_idle();
  endtask

  initial begin
    int base;
    rd_q[0] = 8'hC6; rd_q[1] = 8'h5B;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_eq("R10 reset status", status, 7'h20);
    chk_eq("R12 reset irq_raw", irq_raw, 0);
    chk_eq("R8 reset lines released", {scl_oe, sda_oe}, 0);

    // plain write with START and STOP
    set_mask(1'b1);
    set_addr({TADDR, 1'b0});
    set_txd(8'hA5);
    run_cmd(4'b0111);
    chk_eq("R1 address byte on bus", addr_seen, 8'h74);
    chk_eq("R6 data byte on bus", wr_seen, 8'hA5);
    chk_eq("R4 status after stop", status, 7'h20);
    chk_eq("R12 raw set at end", irq_raw, 1);
    clr_irq();
    chk_eq("R12 clear pulse", irq_raw, 0);

    // data NACK with mask off
    set_mask(1'b0);
    ack_wr = 0;
    run_cmd(4'b0111);
    chk_eq("R6 data nack status", status, 7'h2A);
    chk_eq("R9 error with data nack", status[1], 1);
    chk_eq("R12 masked irq low", irq, 0);
    chk_eq("R12 raw set on failure", irq_raw, 1);
    ack_wr = 1;
    clr_irq();
    set_mask(1'b1);

    // address NACK: data skipped, forced STOP
    base = wr_cnt;
    set_addr({7'h11, 1'b0});
    run_cmd(4'b0011);
    chk_eq("R7 address nack status", status, 7'h26);
    chk_eq("R7 data byte skipped", wr_cnt, base);
    chk_eq("R7 forced stop releases bus", exp_bb, 0);

    // write without stop, repeated START into a two-byte read
    set_addr({TADDR, 1'b0});
    set_txd(8'h3C);
    run_cmd(4'b0011);
    chk_eq("R9 flags cleared on accept", status, 7'h60);
    chk_eq("R4 scl held without stop", scl_oe, 1);
    chk_eq("R6 data byte no stop", wr_seen, 8'h3C);
    base = starts;
    set_addr({TADDR, 1'b1});
    run_cmd(4'b1011);
    chk_eq("R3 repeated start seen", starts, base + 1);
    chk_eq("R1 read address byte", addr_seen, 8'h75);
    chk_eq("R5 first read byte", rx_data, 8'hC6);
    chk_eq("R5 ack driven", mack, 0);
    chk_eq("R4 bus still busy", status, 7'h60);
    base = addr_cnt;
    run_cmd(4'b0101);
    chk_eq("R5 second read byte", rx_data, 8'h5B);
    chk_eq("R5 nack when ack clear", mack, 1);
    chk_eq("R3 no address without start", addr_cnt, base);
    chk_eq("R4 stop after read", status, 7'h20);

    // ignored commands
    base = starts;
    wr_cmd(4'b0110);
    repeat (10) @(negedge clk);
    chk_eq("R2 run clear ignored status", status, 7'h20);
    chk_eq("R2 run clear no start", starts, base);
    set_addr({TADDR, 1'b0});
    set_txd(8'h11);
    base = wr_cnt;
    wr_cmd(4'b0111);
    repeat (20) @(negedge clk);
    wr_cmd(4'b0111);
    wait_idle();
    repeat (30) @(negedge clk);
    chk_eq("R2 command while busy ignored", wr_cnt, base + 1);
    chk_eq("R2 idle after single command", status, 7'h20);

    // arbitration loss on a released address bit
    set_addr(8'h54);
    wr_cmd(4'b0111);
    for (int n = 0; n < 2000 && !exp_bb; n++) @(negedge clk);
    force_low = 1'b1;
    wait_idle();
    chk_eq("R8 arbitration status", status, 7'h72);
    chk_eq("R8 lines released", {scl_oe, sda_oe}, 0);
    force_low = 1'b0;
    repeat (4) @(negedge clk);
    chk_eq("R11 foreign stop clears bus busy", status, 7'h32);

    // recovery: new command clears flags
    set_addr({TADDR, 1'b0});
    run_cmd(4'b0111);
    chk_eq("R9 flags cleared by new command", status, 7'h20);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule